// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block takes single read and write requests from the chip and runs each one as an asynchronous cycle on an external parallel bus. The low 16 address bits and the data share one set of pins. A separate 8-bit port carries the higher address bits. Each cycle starts with an address phase, marked by an address-latch-enable strobe whose active level is set by configuration. A data phase follows, qualified by an active-low read strobe or by active-low write strobes, one for each byte lane.

The top bits of the internal address pick one of four regions. Each region has its own active-low select pin, its own read wait count and its own write wait count. A run-time setting picks the data width. In the wide setting the bus carries 16 data bits. In the narrow setting only the low byte carries data, and the upper half of the shared pins keeps its address byte, so together with the high port up to 24 address bits are available. The shared pins are offered as a separate output, per-byte output-enable and input, so that pad logic outside the block can combine them.

On the chip side the handshake is level-based. The requester holds `req` and the request fields until a one-cycle `ack`, and read data is valid with that `ack`.

Top module: `mux_bus_ctrl`

## Requirements
- R1: `addr[25:24]` selects the region k. During a cycle, `bus_cs_n` has only bit k low. Outside a cycle all four bits are high.
- R2: A cycle starts with exactly one clock of address phase. In it the ALE pin is at its active level, `bus_ad_o` = `addr[15:0]` with both enable bits set, and `bus_ahi` = `addr[23:16]`.
- R3: With `cfg_ale_high`=1 the ALE pin is high when active and low otherwise. With `cfg_ale_high`=0 the levels are inverted.
- R4: A read keeps `bus_rd_n` low for (N+1) clocks. N is the read wait count of the region, taken from `cfg_rd_ws[4k+3:4k]`.
- R5: A write keeps its strobes low for (N+1) clocks. N is the write wait count of the region, taken from `cfg_wr_ws[4k+3:4k]`.
- R6: During a read strobe the low data byte is not driven (`bus_ad_oe[0]`=0). `rdata` holds `bus_ad_i` as sampled on the edge that ends the strobe. `ack` goes high for exactly one clock, right after the strobe.
- R7: In wide mode (`cfg_wide`=1), a write drives `wdata` on `bus_ad_o` with `bus_ad_oe`=2'b11. `bus_wrl_n` goes low only when `be[0]`=1, and `bus_wrh_n` goes low only when `be[1]`=1.
- R8: In narrow mode (`cfg_wide`=0), `bus_ad_o[15:8]` keeps `addr[15:8]` driven through the whole cycle. A write puts `wdata[7:0]` on `bus_ad_o[7:0]` and pulses only `bus_wrl_n`, whatever `be` holds. A read returns `{8'h00, bus_ad_i[7:0]}`.
- R9: No read or write strobe is ever low while ALE is active or while no select is low. Read and write strobes are never low together.
- R10: After reset, all selects and strobes are high, ALE is inactive, `bus_ad_oe`=0 and `ack`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 26 | Bits 25:24 region, bits 23:0 external address |
| wdata | input | 16 | Write data |
| be | input | 2 | Byte enables for a wide write |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read data, valid with ack |
| cfg_wide | input | 1 | 1 = 16-bit data, 0 = 8-bit data |
| cfg_ale_high | input | 1 | 1 = ALE active high |
| cfg_rd_ws | input | 16 | Read wait counts, 4 bits per region |
| cfg_wr_ws | input | 16 | Write wait counts, 4 bits per region |
| bus_cs_n | output | 4 | Region selects, active low |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wrl_n | output | 1 | Low-byte write strobe, active low |
| bus_wrh_n | output | 1 | High-byte write strobe, active low |
| bus_ad_o | output | 16 | Shared address/data pins, out |
| bus_ad_oe | output | 2 | Output enable per byte of the shared pins |
| bus_ad_i | input | 16 | Shared address/data pins, in |
| bus_ahi | output | 8 | High address port |

## Verification
A wait counter loaded with the wrong count shows up within that same cycle: the strobe lasts the wrong number of clocks and `ack` arrives early or late. A wrong latched region or lane shows up at once on the select or write-strobe pins. A sequencer that leaves the address phase late, or drops the output enable late, shows up as ALE overlapping a strobe or as the shared pins being driven during a read. The bench counts the low clocks of each pin during every cycle and compares the counts against the configured wait values, so any of these faults is reported within the cycle where it occurs.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_STRB = 2'd2,
    ST_DONE = 2'd3
  } mbus_state_e;

  // active-high write lanes {high, low} for one write data phase
  function automatic logic [1:0] lane_strobes(input logic wide, input logic [1:0] be);
    logic [1:0] l;
    if (wide) l = be;
    else      l = 2'b01;
    return l;
  endfunction

  // value presented on the shared pins during a data phase
  function automatic logic [15:0] data_phase_bus(input logic wide, input logic wr,
                                                 input logic [15:0] a, input logic [15:0] d);
    logic [15:0] v;
    if (wr && wide) v = d;
    else if (wr)    v = {a[15:8], d[7:0]};
    else            v = {a[15:8], 8'h00};
    return v;
  endfunction

  // read data as returned to the requester
  function automatic logic [15:0] read_merge(input logic wide, input logic [15:0] pins);
    return wide ? pins : {8'h00, pins[7:0]};
  endfunction

endpackage

// File: rtl/mbus_decode.sv
module mbus_decode #(
  parameter int NREG   = 4,
  parameter int WSW    = 4,
  parameter int RSEL_W = 2
) (
  input  logic [RSEL_W-1:0]   sel,
  input  logic [NREG*WSW-1:0] rd_vec,
  input  logic [NREG*WSW-1:0] wr_vec,
  output logic [NREG-1:0]     onehot,
  output logic [WSW-1:0]      rd_ws,
  output logic [WSW-1:0]      wr_ws
);

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign onehot[g] = (sel == RSEL_W'(g));
  end

  always_comb begin
    rd_ws = '0;
    wr_ws = '0;
    for (int i = 0; i < NREG; i++) begin
      if (onehot[i]) begin
        rd_ws = rd_vec[i*WSW +: WSW];
        wr_ws = wr_vec[i*WSW +: WSW];
      end
    end
  end

endmodule

// File: rtl/mbus_waitctr.sv
module mbus_waitctr #(
  parameter int WSW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [WSW-1:0] load_val,
  input  logic           dec,
  output logic           zero
);

  logic [WSW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        cnt_zero,
  output mbus_state_e state,
  output logic        accept,
  output logic        load_cnt,
  output logic        dec_cnt,
  output logic        finish
);

  mbus_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (req) nxt = ST_ADDR;
      ST_ADDR: nxt = ST_STRB;
      ST_STRB: if (cnt_zero) nxt = ST_DONE;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign accept   = (state == ST_IDLE) && req;
  assign load_cnt = (state == ST_ADDR);
  assign dec_cnt  = (state == ST_STRB) && !cnt_zero;
  assign finish   = (state == ST_STRB) && cnt_zero;

  // a data phase is always preceded by an address phase
  assert_addr_before_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STRB) |-> ($past(state) == ST_ADDR || $past(state) == ST_STRB));

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbus_pkg::*;
#(
  parameter int NREG = 4,
  parameter int WSW  = 4,
  parameter int AW   = 26
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [15:0]          wdata,
  input  logic [1:0]           be,
  output logic                 ack,
  output logic [15:0]          rdata,
  input  logic                 cfg_wide,
  input  logic                 cfg_ale_high,
  input  logic [NREG*WSW-1:0]  cfg_rd_ws,
  input  logic [NREG*WSW-1:0]  cfg_wr_ws,
  output logic [NREG-1:0]      bus_cs_n,
  output logic                 bus_ale,
  output logic                 bus_rd_n,
  output logic                 bus_wrl_n,
  output logic                 bus_wrh_n,
  output logic [15:0]          bus_ad_o,
  output logic [1:0]           bus_ad_oe,
  input  logic [15:0]          bus_ad_i,
  output logic [AW-$clog2(NREG)-17:0] bus_ahi
);

  localparam int RSEL_W = $clog2(NREG);
  localparam int LOC_W  = AW - RSEL_W;
  localparam int HI_W   = LOC_W - 16;

  mbus_state_e    state;
  logic           accept, load_cnt, dec_cnt, finish, cnt_zero;
  logic [NREG-1:0] dec_onehot;
  logic [WSW-1:0] dec_rd_ws, dec_wr_ws;

  logic [LOC_W-1:0] a_q;
  logic [15:0]      wd_q;
  logic [1:0]       be_q;
  logic             we_q, wide_q, pol_q;
  logic [NREG-1:0]  sel_q;
  logic [WSW-1:0]   ws_q;
  logic [15:0]      rd_q;

  mbus_decode #(.NREG(NREG), .WSW(WSW), .RSEL_W(RSEL_W)) u_dec (
    .sel    (addr[AW-1 -: RSEL_W]),
    .rd_vec (cfg_rd_ws),
    .wr_vec (cfg_wr_ws),
    .onehot (dec_onehot),
    .rd_ws  (dec_rd_ws),
    .wr_ws  (dec_wr_ws)
  );

  mbus_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .cnt_zero (cnt_zero),
    .state    (state),
    .accept   (accept),
    .load_cnt (load_cnt),
    .dec_cnt  (dec_cnt),
    .finish   (finish)
  );

  mbus_waitctr #(.WSW(WSW)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_cnt),
    .load_val (ws_q),
    .dec      (dec_cnt),
    .zero     (cnt_zero)
  );

  // request and configuration are captured once, at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      wd_q   <= '0;
      be_q   <= '0;
      we_q   <= 1'b0;
      wide_q <= 1'b1;
      pol_q  <= 1'b1;
      sel_q  <= '0;
      ws_q   <= '0;
    end else if (accept) begin
      a_q    <= addr[LOC_W-1:0];
      wd_q   <= wdata;
      be_q   <= be;
      we_q   <= we;
      wide_q <= cfg_wide;
      pol_q  <= cfg_ale_high;
      sel_q  <= dec_onehot;
      ws_q   <= we ? dec_wr_ws : dec_rd_ws;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rd_q <= '0;
    else if (finish && !we_q)  rd_q <= read_merge(wide_q, bus_ad_i);
  end

  // named phase events
  logic addr_ph, data_ph, in_cycle, ale_pol;
  logic [1:0] wr_lanes;
  assign addr_ph  = (state == ST_ADDR);
  assign data_ph  = (state == ST_STRB);
  assign in_cycle = addr_ph || data_ph;
  assign ale_pol  = in_cycle ? pol_q : cfg_ale_high;
  assign wr_lanes = (data_ph && we_q) ? lane_strobes(wide_q, be_q) : 2'b00;

  assign ack       = (state == ST_DONE);
  assign rdata     = rd_q;
  assign bus_cs_n  = in_cycle ? ~sel_q : '1;
  assign bus_ale   = ale_pol ? addr_ph : !addr_ph;
  assign bus_rd_n  = !(data_ph && !we_q);
  assign bus_wrl_n = !wr_lanes[0];
  assign bus_wrh_n = !wr_lanes[1];
  assign bus_ad_o  = data_ph ? data_phase_bus(wide_q, we_q, a_q[15:0], wd_q) : a_q[15:0];
  assign bus_ad_oe[0] = addr_ph || (data_ph && we_q);
  assign bus_ad_oe[1] = addr_ph || (data_ph && (we_q || !wide_q));
  assign bus_ahi   = a_q[LOC_W-1 -: HI_W];

  // strobe run length, kept for checking only
  logic [WSW:0] strb_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       strb_len <= '0;
    else if (addr_ph) strb_len <= '0;
    else if (data_ph) strb_len <= strb_len + 1'b1;
  end

  logic ale_on, strobe_any;
  assign ale_on     = (bus_ale == ale_pol);
  assign strobe_any = !bus_rd_n || !bus_wrl_n || !bus_wrh_n;

  assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));

  assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale_on |=> !ale_on);

  assert_strobe_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> (strb_len == {1'b0, ws_q}));

  assert_read_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_ad_oe[0]);

  assert_ack_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (bus_cs_n == '1 && bus_rd_n && bus_wrl_n && bus_wrh_n));

  assert_narrow_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wrh_n |-> wide_q);

  assert_strobe_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_any |-> (!ale_on && bus_cs_n != '1));

  assert_rw_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && (!bus_wrl_n || !bus_wrh_n)));

endmodule

// File: tb/tb_mux_bus_ctrl.sv
module tb_mux_bus_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [25:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic        ack;
  logic [15:0] rdata;
  logic        cfg_wide = 1'b1, cfg_ale_high = 1'b1;
  logic [15:0] cfg_rd_ws = 16'h025F;  // r0=15 r1=5 r2=2 r3=0
  logic [15:0] cfg_wr_ws = 16'h1073;  // r0=3 r1=7 r2=0 r3=1
  logic [3:0]  bus_cs_n;
  logic        bus_ale, bus_rd_n, bus_wrl_n, bus_wrh_n;
  logic [15:0] bus_ad_o, bus_ad_i;
  logic [1:0]  bus_ad_oe;
  logic [7:0]  bus_ahi;
  logic [15:0] lat_addr = '0;

  int nchk = 0, nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_ad_i = lat_addr ^ 16'hA5C3;

  mux_bus_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata), .be(be),
    .ack(ack), .rdata(rdata), .cfg_wide(cfg_wide), .cfg_ale_high(cfg_ale_high),
    .cfg_rd_ws(cfg_rd_ws), .cfg_wr_ws(cfg_wr_ws), .bus_cs_n(bus_cs_n), .bus_ale(bus_ale),
    .bus_rd_n(bus_rd_n), .bus_wrl_n(bus_wrl_n), .bus_wrh_n(bus_wrh_n), .bus_ad_o(bus_ad_o),
    .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i), .bus_ahi(bus_ahi)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ws_of(input logic [15:0] v, input int k);
    return int'((v >> (k*4)) & 16'hF);
  endfunction

  // observations of one bus cycle
  int n_ale, n_rd, n_wl, n_wh, viol;
  logic [15:0] ale_ad, str_ad, got;
  logic [7:0]  ale_ahi;
  logic [3:0]  ale_cs;
  logic [1:0]  ale_oe, str_oe;
  logic        ack_after;
  logic [3:0]  cs_after;

  task automatic run_cycle(input logic w, input logic [25:0] a, input logic [15:0] d, input logic [1:0] b);
    bit on, stb;
    n_ale = 0; n_rd = 0; n_wl = 0; n_wh = 0; viol = 0;
    str_ad = '0; str_oe = '0; got = '0;
    @(negedge clk);
    we = w; addr = a; wdata = d; be = b; req = 1'b1;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      on  = (bus_ale == cfg_ale_high);
      stb = !bus_rd_n || !bus_wrl_n || !bus_wrh_n;
      if (on) begin
        n_ale++; ale_ad = bus_ad_o; ale_ahi = bus_ahi; ale_cs = bus_cs_n; ale_oe = bus_ad_oe;
        lat_addr = bus_ad_o;
      end
      if (!bus_rd_n)  n_rd++;
      if (!bus_wrl_n) n_wl++;
      if (!bus_wrh_n) n_wh++;
      if (stb) begin str_ad = bus_ad_o; str_oe = bus_ad_oe; end
      if (stb && (on || bus_cs_n == 4'hF)) viol++;
      if (!bus_rd_n && (!bus_wrl_n || !bus_wrh_n)) viol++;
      if (ack) begin got = rdata; break; end
    end
    req = 1'b0;
    @(negedge clk);
    ack_after = ack; cs_after = bus_cs_n;
  endtask

  task automatic t_reset();
    chk(bus_cs_n == 4'hF, "R10 cs idle", bus_cs_n, 4'hF);
    chk(bus_rd_n && bus_wrl_n && bus_wrh_n, "R10 strobes idle",
        {bus_rd_n, bus_wrl_n, bus_wrh_n}, 3'b111);
    chk(bus_ale == 1'b0, "R3 R10 ale idle low", bus_ale, 0);
    chk(bus_ad_oe == 2'b00 && !ack, "R10 oe/ack", {bus_ad_oe, ack}, 0);
  endtask

  task automatic t_read16();
    for (int r = 0; r < 4; r++) begin
      logic [25:0] a;
      a = {r[1:0], 8'h30 + 8'(r), 16'h1234 + 16'(r * 16'h1111)};
      run_cycle(1'b0, a, 16'h0, 2'b11);
      chk(n_ale == 1, "R2 one ale clock", n_ale, 1);
      chk(ale_ad == a[15:0] && ale_oe == 2'b11, "R2 address on bus", ale_ad, a[15:0]);
      chk(ale_ahi == a[23:16], "R2 high address", ale_ahi, a[23:16]);
      chk(ale_cs == ~(4'b1 << r), "R1 region select", ale_cs, ~(4'b1 << r));
      chk(n_rd == ws_of(cfg_rd_ws, r) + 1, "R4 read strobe length", n_rd, ws_of(cfg_rd_ws, r) + 1);
      chk(str_oe[0] == 1'b0, "R6 bus released", str_oe, 0);
      chk(got == (a[15:0] ^ 16'hA5C3), "R6 read data", got, a[15:0] ^ 16'hA5C3);
      chk(!ack_after && cs_after == 4'hF, "R6 R1 ack pulse and release", {ack_after, cs_after}, 5'h0F);
      chk(viol == 0 && n_wl == 0 && n_wh == 0, "R9 strobe qualification", viol, 0);
    end
  endtask

  task automatic t_write16();
    logic [1:0] bes [3] = '{2'b11, 2'b01, 2'b10};
    for (int i = 0; i < 3; i++) begin
      int r; logic [25:0] a; logic [15:0] d; int len;
      r = (i == 1) ? 2 : (i == 0 ? 1 : 3);
      a = {r[1:0], 8'hC0, 16'h0F00 + 16'(i)};
      d = 16'hBEE0 + 16'(i);
      len = ws_of(cfg_wr_ws, r) + 1;
      run_cycle(1'b1, a, d, bes[i]);
      chk(n_wl == (bes[i][0] ? len : 0), "R7 R5 low lane strobe", n_wl, bes[i][0] ? len : 0);
      chk(n_wh == (bes[i][1] ? len : 0), "R7 R5 high lane strobe", n_wh, bes[i][1] ? len : 0);
      chk(str_ad == d && str_oe == 2'b11, "R7 write data", str_ad, d);
      chk(viol == 0 && n_rd == 0, "R9 write strobes", viol, 0);
    end
  endtask

  task automatic t_narrow();
    logic [25:0] a;
    cfg_wide = 1'b0;
    a = {2'd1, 8'h77, 16'hAB12};
    run_cycle(1'b1, a, 16'h9C5D, 2'b10);
    chk(n_wh == 0, "R8 no high strobe", n_wh, 0);
    chk(n_wl == ws_of(cfg_wr_ws, 1) + 1, "R8 R5 low strobe", n_wl, ws_of(cfg_wr_ws, 1) + 1);
    chk(str_ad == 16'hAB5D, "R8 narrow write bus", str_ad, 16'hAB5D);
    a = {2'd2, 8'h11, 16'h4C21};
    run_cycle(1'b0, a, 16'h0, 2'b11);
    chk(got == {8'h00, 8'h21 ^ 8'hC3}, "R8 narrow read data", got, {8'h00, 8'h21 ^ 8'hC3});
    chk(str_oe == 2'b10 && str_ad[15:8] == 8'h4C, "R8 address byte held", {str_oe, str_ad}, {2'b10, 16'h4C00});
    chk(n_rd == ws_of(cfg_rd_ws, 2) + 1, "R4 narrow read length", n_rd, ws_of(cfg_rd_ws, 2) + 1);
    cfg_wide = 1'b1;
  endtask

  task automatic t_polarity();
    cfg_ale_high = 1'b0;
    @(negedge clk);
    chk(bus_ale == 1'b1, "R3 idle level inverted", bus_ale, 1);
    run_cycle(1'b0, {2'd3, 8'h01, 16'h5555}, 16'h0, 2'b11);
    chk(n_ale == 1 && ale_ad == 16'h5555, "R3 active low ale", n_ale, 1);
    chk(n_rd == 1 && viol == 0, "R3 R4 zero wait read", n_rd, 1);
    chk(bus_ale == 1'b1, "R3 back to idle level", bus_ale, 1);
    cfg_ale_high = 1'b1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_read16();
    t_write16();
    t_narrow();
    t_polarity();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule